// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a tick timer that a processor core programs through two special registers. The first is a control register. It holds a two-bit run mode, an interrupt enable, a sticky pending flag and a 28-bit period. The second is a 32-bit count register that software can write and read directly. Whenever the clock enable is high and the timer is running, the count advances by one. When the low 28 bits of the count equal the period, the block sets the pending flag. The mode then decides what happens next: the count restarts from zero, the count freezes, or the count carries on.

A register decoder outside this block produces one write strobe and one data word for each register, and it reads both register values back. Software can never set the pending flag. On a control write it can only keep the flag or clear it. The timer starts or stops only when a control write actually changes the mode code. A write that repeats the current code leaves the run state as it is.

Top module: `tick_timer`

## Requirements
- R1: While reset is active, and after it has been released, the control register reads 0, the count reads 0, the interrupt output is low and the timer is stopped, so clock-enable cycles leave the count at 0.
- R2: A control write loads bits 31:30 as the mode (00 off, 01 restart, 10 one-shot, 11 continuous), bit 29 as the interrupt enable and bits 27:0 as the period. The new value reads back on the control port after the clock edge.
- R3: If a control write has bit 28 at 1, the pending flag keeps its current value, so a write never raises it. If a control write has bit 28 at 0, the pending flag clears and the interrupt output drops.
- R4: A control write that changes the mode to 00 stops the timer. A control write that changes the mode to any other code starts the timer. A write that repeats the current mode code leaves the run state unchanged. The new run state applies from the cycle after the write.
- R5: While the timer is running, the count rises by one in each cycle that has the clock enable high. The count holds in any cycle with the clock enable low, and in any cycle where the timer is stopped.
- R6: A match occurs in a counting cycle where count bits 27:0 equal the period, even if count bits 31:28 are nonzero. A match sets the pending flag on the next edge.
- R7: In restart mode, a match returns the count to 0.
- R8: In one-shot mode, a match stops the timer. The count then stays at the matching value.
- R9: In continuous mode, a match leaves the count advancing past the period.
- R10: A count write loads the count and reads back after the edge. It takes priority over the increment in the same cycle, and no match is evaluated in that cycle.
- R11: The interrupt output is high exactly while the pending flag and the interrupt enable are both 1.
- R12: When a control write and a match fall in the same cycle, a write with bit 28 at 0 wins and pending ends at 0. A write with bit 28 at 1 lets the match set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable for counting |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 32 | Count register write data |
| ctl_rdata | output | 32 | Control register read value |
| cnt_rdata | output | 32 | Count register read value |
| irq | output | 1 | Timer interrupt request |

## Verification
Each of the three running modes is taken through a match so that its behaviour after the match can be told apart: the count wraps to zero, freezes, or runs on. Control writes are issued with the pending bit at 1 and at 0, with and without the interrupt enable, and with the mode both repeated and changed. These writes separate a keep from a clear, and a real mode change from a repeated code that must leave the run state alone. Count writes are placed in counting cycles to confirm that the write beats the increment. One count value has nonzero upper bits so that the match can be seen to use the low 28 bits only. Finally, a control write is placed on the exact match cycle, once with the pending bit at 1 and once at 0.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_FREE    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tt_cfg_reg.sv
module tt_cfg_reg
  import tt_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          match_hit,
  output tt_mode_e      mode,
  output logic          ie,
  output logic          pend,
  output logic [PW-1:0] period
);
  localparam int MODE_HI = DW - 1;
  localparam int IE_BIT  = DW - 3;
  localparam int PND_BIT = DW - 4;

  tt_mode_e      mode_q, mode_d;
  logic          ie_q, ie_d;
  logic          pend_q, pend_d;
  logic [PW-1:0] per_q, per_d;

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    per_d  = per_q;
    pend_d = pend_q | match_hit;
    if (we) begin
      mode_d = tt_mode_e'(wdata[MODE_HI -: 2]);
      ie_d   = wdata[IE_BIT];
      per_d  = wdata[PW-1:0];
      // software may keep or clear pending, never raise it
      pend_d = wdata[PND_BIT] ? (pend_q | match_hit) : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TT_OFF;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      per_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      pend_q <= pend_d;
      per_q  <= per_d;
    end
  end

  assign mode   = mode_q;
  assign ie     = ie_q;
  assign pend   = pend_q;
  assign period = per_q;
endmodule

// File: rtl/tt_run_ctrl.sv
module tt_run_ctrl
  import tt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  tt_mode_e wmode,
  input  tt_mode_e cur_mode,
  input  logic     match_hit,
  output logic     run
);
  logic run_q, run_d;
  logic mode_change;

  assign mode_change = we && (wmode != cur_mode);

  always_comb begin
    run_d = run_q;
    if (mode_change)
      run_d = (wmode != TT_OFF);
    else if (match_hit && cur_mode == TT_ONESHOT)
      run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run = run_q;
endmodule

// File: rtl/tt_count_unit.sv
module tt_count_unit
  import tt_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  tt_mode_e      mode,
  input  logic [PW-1:0] period,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic          match_hit
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          eval;

  assign eval      = tick_en && run && !we;
  assign match_hit = eval && (cnt_q[PW-1:0] == period);

  always_comb begin
    cnt_d = cnt_q;
    if (we) begin
      cnt_d = wdata;
    end else if (eval) begin
      if (match_hit && mode == TT_RESTART)
        cnt_d = '0;
      else if (match_hit && mode == TT_ONESHOT)
        cnt_d = cnt_q;
      else
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int DW = 32,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          cnt_we,
  input  logic [DW-1:0] cnt_wdata,
  output logic [DW-1:0] ctl_rdata,
  output logic [DW-1:0] cnt_rdata,
  output logic          irq
);
  localparam int PW      = DW - 4;
  localparam int MODE_HI = DW - 1;

  logic          rst_n_i;
  tt_mode_e      mode;
  logic          ie, pend, run, match_hit;
  logic [PW-1:0] period;

  tt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  tt_cfg_reg #(.DW(DW), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .we(ctl_we), .wdata(ctl_wdata),
    .match_hit(match_hit), .mode(mode), .ie(ie), .pend(pend), .period(period)
  );

  tt_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n_i), .we(ctl_we),
    .wmode(tt_mode_e'(ctl_wdata[MODE_HI -: 2])), .cur_mode(mode),
    .match_hit(match_hit), .run(run)
  );

  tt_count_unit #(.DW(DW), .PW(PW)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .tick_en(tick_en), .run(run), .mode(mode),
    .period(period), .we(cnt_we), .wdata(cnt_wdata),
    .count(cnt_rdata), .match_hit(match_hit)
  );

  assign ctl_rdata = {mode, ie, pend, period};
  assign irq       = pend & ie;
endmodule

// File: rtl/tt_chk.sv
module tt_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          ctl_we,
  input logic [DW-1:0] ctl_wdata,
  input logic          cnt_we,
  input logic [DW-1:0] cnt_wdata,
  input logic [DW-1:0] ctl_rdata,
  input logic [DW-1:0] cnt_rdata,
  input logic          irq
);
  localparam int PND = DW - 4;
  localparam int IEB = DW - 3;

  // R3
  clear_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !ctl_wdata[PND] |=> !ctl_rdata[PND] && !irq);

  // R3
  keep_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[PND] && ctl_rdata[PND] |=> ctl_rdata[PND]);

  // R6
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[PND]) |-> $past(tick_en) && !$past(cnt_we));

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata[PND-1:0] == $past(ctl_wdata[PND-1:0])
               && ctl_rdata[DW-1:IEB] == $past(ctl_wdata[DW-1:IEB]));

  // R10
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_rdata == $past(cnt_wdata));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cnt_we |=> $stable(cnt_rdata));

  // R11
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ctl_rdata[IEB] && ctl_rdata[PND]));
endmodule

bind tick_timer tt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
  .ctl_wdata(ctl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata), .irq(irq)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, ctl_we, cnt_we;
  logic [31:0] ctl_wdata, cnt_wdata;
  logic [31:0] ctl_rdata, cnt_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        mwe;
    logic [31:0] mw;
    logic        cwe;
    logic [31:0] cw;
    logic        tick;
    logic [31:0] em;
    logic [31:0] ec;
    logic        ei;
  } vec_t;

  localparam int NV = 27;
  localparam logic [131:0] VEC [NV] = '{
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'h0,         32'd0,         1'b0}, // 0 R1/R5 stopped
    {1'b0, 32'h0,         1'b1, 32'd5,         1'b1, 32'h0,         32'd5,         1'b0}, // 1 R10
    {1'b1, 32'h6000_0007, 1'b0, 32'h0,         1'b0, 32'h6000_0007, 32'd5,         1'b0}, // 2 R2/R4 start
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'h6000_0007, 32'd6,         1'b0}, // 3 R5
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'h6000_0007, 32'd7,         1'b0}, // 4 R5
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'h7000_0007, 32'd0,         1'b1}, // 5 R6/R7/R11
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 32'h7000_0007, 32'd0,         1'b1}, // 6 R5 hold
    {1'b1, 32'h7000_0007, 1'b0, 32'h0,         1'b1, 32'h7000_0007, 32'd1,         1'b1}, // 7 R3 keep/R4 same
    {1'b1, 32'h5000_0007, 1'b0, 32'h0,         1'b1, 32'h5000_0007, 32'd2,         1'b0}, // 8 R11 ie off
    {1'b1, 32'h6000_0007, 1'b0, 32'h0,         1'b1, 32'h6000_0007, 32'd3,         1'b0}, // 9 R3 clear
    {1'b1, 32'h3000_0007, 1'b0, 32'h0,         1'b1, 32'h2000_0007, 32'd4,         1'b0}, // 10 R4 stop
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'h2000_0007, 32'd4,         1'b0}, // 11 R4 stopped
    {1'b1, 32'h3000_0007, 1'b0, 32'h0,         1'b1, 32'h2000_0007, 32'd4,         1'b0}, // 12 R3 no set
    {1'b1, 32'hA000_000A, 1'b1, 32'd9,         1'b1, 32'hA000_000A, 32'd9,         1'b0}, // 13 R2 one-shot
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'hA000_000A, 32'd10,        1'b0}, // 14
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'hB000_000A, 32'd10,        1'b1}, // 15 R8
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'hB000_000A, 32'd10,        1'b1}, // 16 R8
    {1'b1, 32'hB000_000A, 1'b0, 32'h0,         1'b1, 32'hB000_000A, 32'd10,        1'b1}, // 17 R4 same code
    {1'b1, 32'hE000_0003, 1'b1, 32'd2,         1'b0, 32'hE000_0003, 32'd2,         1'b0}, // 18 R4 start
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'hE000_0003, 32'd3,         1'b0}, // 19
    {1'b1, 32'hF000_0003, 1'b0, 32'h0,         1'b1, 32'hF000_0003, 32'd4,         1'b1}, // 20 R9/R12 keep
    {1'b1, 32'hE000_0003, 1'b0, 32'h0,         1'b1, 32'hE000_0003, 32'd5,         1'b0}, // 21 R3
    {1'b0, 32'h0,         1'b1, 32'h1000_0003, 1'b1, 32'hE000_0003, 32'h1000_0003, 1'b0}, // 22 R10
    {1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 32'hF000_0003, 32'h1000_0004, 1'b1}, // 23 R6 low bits
    {1'b0, 32'h0,         1'b1, 32'd3,         1'b1, 32'hF000_0003, 32'd3,         1'b1}, // 24 R10
    {1'b1, 32'hE000_0003, 1'b0, 32'h0,         1'b1, 32'hE000_0003, 32'd4,         1'b0}, // 25 R12 clear wins
    {1'b0, 32'h0,         1'b1, 32'd3,         1'b1, 32'hE000_0003, 32'd3,         1'b0}  // 26 R10 no match
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_we = 0; cnt_we = 0; tick_en = 0; ctl_wdata = '0; cnt_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ctl", ctl_rdata, 32'h0);
    check("R1 reset cnt", cnt_rdata, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      @(negedge clk);
      ctl_we = v.mwe; ctl_wdata = v.mw;
      cnt_we = v.cwe; cnt_wdata = v.cw; tick_en = v.tick;
      step();
      check($sformatf("vec%0d R2/R3/R4 ctl", i), ctl_rdata, v.em);
      check($sformatf("vec%0d R5..R10 cnt", i), cnt_rdata, v.ec);
      check($sformatf("vec%0d R11 irq", i), {31'h0, irq}, {31'h0, v.ei});
    end

    // R6 match after the written value in continuous mode (count 3, period 3)
    @(negedge clk); idle(); tick_en = 1;
    step();
    check("R6 match after write", ctl_rdata, 32'hF000_0003);
    check("R9 runs on", cnt_rdata, 32'd4);

    // R1 reset in the middle of a run
    @(negedge clk); rst_n = 0; #1;
    check("R1 mid reset ctl", ctl_rdata, 32'h0);
    check("R1 mid reset cnt", cnt_rdata, 32'h0);
    check("R1 mid reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1;
    repeat (6) @(posedge clk);
    #1;
    check("R1 stopped after reset", cnt_rdata, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule